// File: doc/BRIEF.md
# Asynchronous ROM Read-Cycle Controller

This block sits between a synchronous host and an asynchronous parallel ROM. When the host raises a request with an address, the controller does four things. It drives that address and pulls the ROM's chip enable low. It pulls the output enable low late enough that the enable's own, shorter access delay ends together with the address and chip-enable delays. It captures the data on the clock edge at which the longest delay has elapsed. It then releases both enables and stays busy until the ROM's data drivers can be assumed to have floated off the shared bus.

Every delay is given in nanoseconds and converted to clock cycles by rounding up against a clock-period parameter. The ROM has two speed grades with different address and chip-enable access times. The grade is picked per transaction by an input that is sampled when the request is accepted. With the defaults (5 ns clock):

| Grade | Access time (address and chip enable) | Output-enable access time | Output float time |
|-------|---------------------------------------|---------------------------|-------------------|
| fast  | 350 ns = 70 cycles                    | 120 ns = 24 cycles        | 100 ns = 20 cycles |
| slow  | 450 ns = 90 cycles                    | 120 ns = 24 cycles        | 100 ns = 20 cycles |

The state machine has four states:

| State | Meaning | Exit |
|-------|---------|------|
| ST_IDLE | Waiting for a request. | A request moves it to ST_LEAD. It moves straight to ST_SENSE when the output-enable delay is not shorter than the access delay. |
| ST_LEAD | Chip enable is low and output enable is still high. | When the lead count expires, output enable goes low and the state becomes ST_SENSE. |
| ST_SENSE | Both enables are low. | When the sense count expires, the data is captured, both enables rise and the state becomes ST_FLOAT. |
| ST_FLOAT | Bus turnaround. | When the float count expires, the state becomes ST_IDLE. |

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is held and after it is released: busy=0, rvalid=0, rdata=0, rom_addr=0, rom_ce_n=1, rom_oe_n=1.
- R2: A request seen at a clock edge while busy is 0 is accepted at that edge. After that edge rom_addr equals req_addr, rom_ce_n is 0 and busy is 1.
- R3: After acceptance rom_ce_n stays 0 for exactly ACC cycles, where ACC = ceil(access_ns / CLK_NS): 70 for the fast grade (spd_slow=0) and 90 for the slow grade (spd_slow=1) at the defaults.
- R4: rom_oe_n goes 0 exactly ACC-OE cycles after rom_ce_n falls (OE = 24 at the defaults). It rises on the same edge as rom_ce_n, and it is never 0 while rom_ce_n is 1.
- R5: On the edge that releases the enables, rdata takes the value on rom_data. rvalid is 1 for exactly that one cycle.
- R6: busy stays 1 for FLT cycles after the enables rise (FLT = 20 at the defaults). The next acceptance comes no earlier than FLT+1 cycles after the release.
- R7: A request raised while busy is 1 is ignored. rom_addr does not change until a later acceptance.
- R8: The grade is sampled only at acceptance. A change of spd_slow during a transaction does not alter its timing.
- R9: rdata holds its value until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, level-sampled |
| req_addr | input | ADDR_W | Address of the requested read |
| spd_slow | input | 1 | ROM speed grade: 1 selects the slow grade |
| busy | output | 1 | A transaction or the float time is in progress |
| rvalid | output | 1 | One-cycle pulse when rdata is updated |
| rdata | output | DATA_W | Captured read data |
| rom_addr | output | ADDR_W | Address driven to the ROM |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_data | input | DATA_W | Data lines from the ROM |

## Verification
The assertions check the window and gap lengths against the two grade counts. They assume the clock-period parameter is consistent with the real clock, and that a request's address is stable at the edge where it is sampled. They make no assumption about how long req stays high. The stimulus holds req high for several cycles, raises it again during busy with a different address, flips spd_slow in the middle of a transaction, and keeps req high across back-to-back reads. The bench's ROM model returns the inverted word whenever any of the three access delays has not yet elapsed, so a capture made too early shows up as a data mismatch.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SENSE,
        ST_FLOAT
    } rd_state_e;

    // Converts a delay in ns to clock cycles, rounding up.
    function automatic int ns2cyc(input int dly_ns, input int per_ns);
        return (dly_ns + per_ns - 1) / per_ns;
    endfunction

endpackage

// File: rtl/rom_rd_timing.sv
module rom_rd_timing #(
    parameter int CNT_W    = 8,
    parameter int FAST_ACC = 70,
    parameter int SLOW_ACC = 90,
    parameter int OE_ACC   = 24
) (
    input  logic             slow,
    output logic [CNT_W-1:0] lead_cyc,
    output logic [CNT_W-1:0] sense_cyc
);
    int acc;
    int lead;
    int rest;

    always_comb begin
        acc  = slow ? SLOW_ACC : FAST_ACC;
        lead = (acc > OE_ACC) ? (acc - OE_ACC) : 0;
        rest = acc - lead;
        // The longer of the two remaining paths sets the sense window.
        if (rest < OE_ACC) rest = OE_ACC;
        lead_cyc  = CNT_W'(lead);
        sense_cyc = CNT_W'(rest);
    end
endmodule

// File: rtl/rom_rd_count.sv
module rom_rd_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= ld_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/rom_rd_fsm.sv
module rom_rd_fsm
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int FLT    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              spd_slow,
    input  logic [CNT_W-1:0]  lead_cyc,
    input  logic [CNT_W-1:0]  sense_cyc,
    input  logic              cnt_zero,
    input  logic [DATA_W-1:0] rom_data,
    output logic              grade_sel,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n
);
    localparam logic [CNT_W-1:0] FLT_LD = CNT_W'(FLT - 1);

    rd_state_e state, nxt;
    logic      grade_q;
    logic      accept;
    logic      capture;

    // The grade decoder sees the live input only while idle.
    assign grade_sel = (state == ST_IDLE) ? spd_slow : grade_q;
    assign accept    = (state == ST_IDLE) && req;
    assign capture   = (state == ST_SENSE) && cnt_zero;

    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    cnt_load = 1'b1;
                    if (lead_cyc != '0) begin
                        nxt     = ST_LEAD;
                        cnt_val = lead_cyc - 1'b1;
                    end else begin
                        nxt     = ST_SENSE;
                        cnt_val = sense_cyc - 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (cnt_zero) begin
                    nxt      = ST_SENSE;
                    cnt_load = 1'b1;
                    cnt_val  = sense_cyc - 1'b1;
                end
            end
            ST_SENSE: begin
                if (cnt_zero) begin
                    nxt      = ST_FLOAT;
                    cnt_load = 1'b1;
                    cnt_val  = FLT_LD;
                end
            end
            ST_FLOAT: begin
                if (cnt_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grade_q  <= 1'b0;
            busy     <= 1'b0;
            rvalid   <= 1'b0;
            rdata    <= '0;
            rom_addr <= '0;
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
        end else begin
            busy     <= (nxt != ST_IDLE);
            rom_ce_n <= !((nxt == ST_LEAD) || (nxt == ST_SENSE));
            rom_oe_n <= (nxt != ST_SENSE);
            rvalid   <= capture;
            if (capture) rdata <= rom_data;
            if (accept) begin
                rom_addr <= req_addr;
                grade_q  <= spd_slow;
            end
        end
    end
endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 5,
    parameter int FAST_ACC_NS = 350,
    parameter int SLOW_ACC_NS = 450,
    parameter int OE_ACC_NS   = 120,
    parameter int FLOAT_NS    = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              spd_slow,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_data
);
    localparam int FAST_ACC = ns2cyc(FAST_ACC_NS, CLK_NS);
    localparam int SLOW_ACC = ns2cyc(SLOW_ACC_NS, CLK_NS);
    localparam int OE_ACC   = ns2cyc(OE_ACC_NS, CLK_NS);
    localparam int FLT      = ns2cyc(FLOAT_NS, CLK_NS);
    localparam int MAX_CYC  = (SLOW_ACC > FAST_ACC) ? SLOW_ACC : FAST_ACC;
    localparam int CNT_W    = $clog2(MAX_CYC + FLT + 1);

    logic             grade_sel;
    logic [CNT_W-1:0] lead_cyc;
    logic [CNT_W-1:0] sense_cyc;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;

    rom_rd_timing #(
        .CNT_W(CNT_W), .FAST_ACC(FAST_ACC), .SLOW_ACC(SLOW_ACC), .OE_ACC(OE_ACC)
    ) u_timing (
        .slow(grade_sel), .lead_cyc(lead_cyc), .sense_cyc(sense_cyc)
    );

    rom_rd_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .ld_val(cnt_val), .zero(cnt_zero)
    );

    rom_rd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FLT(FLT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .spd_slow(spd_slow), .lead_cyc(lead_cyc), .sense_cyc(sense_cyc),
        .cnt_zero(cnt_zero), .rom_data(rom_data), .grade_sel(grade_sel),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .busy(busy), .rvalid(rvalid),
        .rdata(rdata), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n)
    );
endmodule

// File: rtl/rom_rd_chk.sv
module rom_rd_chk #(
    parameter int ADDR_W   = 11,
    parameter int FAST_ACC = 70,
    parameter int SLOW_ACC = 90,
    parameter int FLT      = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rvalid,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n
);
    logic [15:0] low_len;
    logic [15:0] gap_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len <= '0;
            gap_len <= 16'hFFFF;
        end else begin
            low_len <= rom_ce_n ? 16'd0 : low_len + 16'd1;
            if (!rom_ce_n)              gap_len <= '0;
            else if (gap_len != 16'hFFFF) gap_len <= gap_len + 16'd1;
        end
    end

    // R2
    idle_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rom_ce_n);
    // R3
    ce_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_ce_n) |-> (low_len == 16'(FAST_ACC) || low_len == 16'(SLOW_ACC)));
    // R4
    oe_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
    // R5
    capture_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> ($past(!rom_oe_n) && rom_oe_n && rom_ce_n));
    // R6
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_ce_n) |-> (gap_len >= 16'(FLT + 1)));
    // R6
    busy_over_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_ce_n) |-> busy);
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));
endmodule

bind rom_rd_ctrl rom_rd_chk #(
    .ADDR_W(ADDR_W), .FAST_ACC(FAST_ACC), .SLOW_ACC(SLOW_ACC), .FLT(FLT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rvalid(rvalid),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n)
);

// File: tb/sim_rom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_rom_rd_ctrl;
    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int FA  = (350 + 4) / 5;
    localparam int SA  = (450 + 4) / 5;
    localparam int OEC = (120 + 4) / 5;
    localparam int FL  = (100 + 4) / 5;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req = 0;
    logic [AW-1:0] req_addr = '0;
    logic          spd_slow = 0;
    logic          busy, rvalid, rom_ce_n, rom_oe_n;
    logic [DW-1:0] rdata, rom_data;
    logic [AW-1:0] rom_addr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rom_rd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .spd_slow(spd_slow), .busy(busy), .rvalid(rvalid), .rdata(rdata),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_data(rom_data)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return a[7:0] ^ 8'(a >> 3) ^ 8'h6B;
    endfunction

    // ROM model: the true word only once every delay will have elapsed by the next edge.
    int ce_age = 0, oe_age = 0, ad_age = 0;
    logic [AW-1:0] last_addr = '0;
    always @(negedge clk) begin
        ce_age = rom_ce_n ? 0 : ce_age + 1;
        oe_age = rom_oe_n ? 0 : oe_age + 1;
        ad_age = (rom_addr != last_addr) ? 1 : ad_age + 1;
        last_addr = rom_addr;
        if (!rom_ce_n && !rom_oe_n && ce_age >= (u0_grade() ? SA : FA) &&
            ad_age >= (u0_grade() ? SA : FA) && oe_age >= OEC)
            rom_data = word_of(rom_addr);
        else
            rom_data = ~word_of(rom_addr);
    end

    // Reference timeline, driven by the cycle index of acceptance.
    int cyc = 0;
    int t0 = -100000;
    bit g_m = 0;
    logic [AW-1:0] a_m = '0;
    logic [DW-1:0] d_m = '0;
    function automatic bit u0_grade();
        return g_m;
    endfunction

    always @(posedge clk) begin
        int acc;
        cyc = cyc + 1;
        if (!rst_n) begin
            t0 = -100000; a_m = '0; d_m = '0; g_m = 0;
        end else begin
            acc = g_m ? SA : FA;
            if (req && (cyc - t0) > acc + FL) begin
                t0 = cyc; g_m = spd_slow; a_m = req_addr;
            end
            acc = g_m ? SA : FA;
            if (cyc - t0 == acc) d_m = word_of(a_m);
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int k, acc;
        if (!done) begin
            k   = cyc - t0;
            acc = g_m ? SA : FA;
            vectors++;
            cmp("R3 rom_ce_n", int'(rom_ce_n), int'(!(rst_n && k < acc)));
            cmp("R4 rom_oe_n", int'(rom_oe_n), int'(!(rst_n && k >= acc - OEC && k < acc)));
            cmp("R6 busy", int'(busy), int'(rst_n && k < acc + FL));
            cmp("R5 rvalid", int'(rvalid), int'(rst_n && k == acc));
            cmp("R9 rdata", int'(rdata), int'(d_m));
            cmp("R7 rom_addr", int'(rom_addr), int'(a_m));
        end
    end

    task automatic read_op(input logic [AW-1:0] a, input bit slow, input int hold);
        @(negedge clk);
        req = 1; req_addr = a; spd_slow = slow;
        repeat (hold) @(negedge clk);
        req = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic direct(input string tag, input int act, input int exp);
        vectors++;
        cmp(tag, act, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        direct("R1 busy", int'(busy), 0);
        direct("R1 rom_ce_n", int'(rom_ce_n), 1);
        direct("R1 rdata", int'(rdata), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        direct("R1 rom_oe_n after release", int'(rom_oe_n), 1);

        // R2: acceptance on the first edge with req high
        @(negedge clk);
        req = 1; req_addr = 11'h123; spd_slow = 0;
        @(negedge clk);
        req = 0;
        direct("R2 rom_addr", int'(rom_addr), 'h123);
        direct("R2 rom_ce_n", int'(rom_ce_n), 0);
        while (busy) @(negedge clk);
        direct("R5 rdata fast", int'(rdata), int'(word_of(11'h123)));

        read_op(11'h7FF, 1, 1);
        direct("R5 rdata slow", int'(rdata), int'(word_of(11'h7FF)));
        read_op(11'h000, 0, 3);

        // R7: a second request during busy with another address
        @(negedge clk);
        req = 1; req_addr = 11'h055; spd_slow = 0;
        @(negedge clk);
        req_addr = 11'h2AA;
        repeat (10) @(negedge clk);
        req = 0;
        direct("R7 rom_addr held", int'(rom_addr), 'h055);
        while (busy) @(negedge clk);
        direct("R7 rdata", int'(rdata), int'(word_of(11'h055)));

        // R8: grade flips during a slow transaction
        @(negedge clk);
        req = 1; req_addr = 11'h3C1; spd_slow = 1;
        @(negedge clk);
        req = 0; spd_slow = 0;
        while (busy) @(negedge clk);
        direct("R8 rdata after grade flip", int'(rdata), int'(word_of(11'h3C1)));

        // R6: req held high across back-to-back reads
        @(negedge clk);
        req = 1; req_addr = 11'h4E7; spd_slow = 0;
        repeat (250) @(negedge clk);
        req = 0;
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        direct("R9 rdata held", int'(rdata), int'(word_of(11'h4E7)));

        read_op(11'h1F0, 1, 2);
        read_op(11'h60F, 0, 1);
        repeat (5) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5 * 100000);
        done = 1;
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule